// File: doc/BRIEF.md
# Quad Prescaled Countdown Timer Bank

Four identical 24-bit down-counters share one small register window. Every timer owns a group of four word registers: a reload value, the live count, a control word and an acknowledge register. The groups sit 0x20 bytes apart, and address bits 6:5 pick the timer. Counting advances only on cycles where the free-running `tick_en` input is high. A per-timer prescaler setting divides those ticks by 1, 16 or 256.

When a running timer counts down to zero, it raises its own level interrupt line. The line stays high until software touches the timer. In periodic mode, an access to the acknowledge register drops the line, reloads the count and lets the timer run again. In one-shot mode, the acknowledge only drops the line. The count then stays at zero until software gives the timer a new start value.

The bus is a plain synchronous port with `addr`, `wdata`, `wr_en`, `rd_en` and `rdata`. Read data is registered and appears one cycle after the read strobe.

Top module: `qtimer_bank`

## Requirements
- R1: Timer k (k = 0..3) takes its index from addr[6:5]. Within its group, addr[3:2] selects the register: 0 = reload (offset 0x00), 1 = count (0x04), 2 = control (0x08), 3 = acknowledge (0x0C). An address with addr[7] or addr[4] set selects nothing: a read of it returns 0 and a write to it changes nothing. addr[1:0] is ignored.
- R2: After reset, every timer has control = 0x2 (periodic, disabled, divide-by-1), reload = 0xFFFFFF and count = 0xFFFFFF. All interrupt lines are low and `rdata` is 0.
- R3: A write to the reload register stores wdata[23:0]. In the same edge it copies that value into the count, and the timer's interrupt is low from the next cycle on.
- R4: The control register uses bit0 = enable, bit1 = periodic, bit2 = divide-by-16 and bit3 = divide-by-256. Bits above 3 are dropped and read as zero. Any control write drops the interrupt. A control write with enable set also reloads the count from the reload register. A control write with enable clear discards any pending interrupt, and the timer stops.
- R5: A read or a write of the acknowledge register drops that timer's interrupt. In periodic mode, the same access also reloads the count from the reload register. A read of this register returns 0.
- R6: A shared 8-bit event counter advances on every `tick_en` cycle. A divide-by-1 timer steps on every `tick_en` cycle. A divide-by-16 timer steps when `tick_en` is high and the counter's low nibble is 15. A divide-by-256 timer steps when `tick_en` is high and the counter is 255. With both divide bits set, the timer divides by 256.
- R7: A step on an enabled timer works as follows. If the count is above 1, the count decrements. If the count is 0 or 1, the count becomes 0 and the interrupt goes high. The interrupt then stays high until a reload, control or acknowledge access to that timer.
- R8: A periodic timer runs again from its reload value as soon as its interrupt is acknowledged.
- R9: After a one-shot timer expires and is acknowledged, it stays at zero and raises no new interrupt. It restarts only after a reload write, a control write with enable set, or a write to the count register.
- R10: The count register can be read and written; a write stores wdata[23:0]. All read data is zero-extended to 32 bits. `rdata` is updated on the edge where `rd_en` is sampled high and holds its value otherwise. A read returns the register's value from before that edge.
- R11: A timer whose enable bit is clear does not change its count.
- R12: In any cycle, a bus write or acknowledge access to a timer takes precedence over that timer's count step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Free-running count enable |
| addr | input | 8 | Byte address within the register window |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| irq | output | 4 | Level interrupt, one per timer |

## Verification
The assertions check the following on every cycle:
- After a reload write, a control write or an acknowledge access, the addressed interrupt line is low.
- A raised line stays high while its timer is left untouched.
- `rdata` holds still without a read strobe, never has bits above 23 set, and reads zero outside the window.

The prescale phases, the periodic restart, the one-shot hold at zero and the masking of written values depend on counted sequences of ticks and accesses. Only the bench's cycle-by-cycle reference model and its directed scenarios can show those.

// File: rtl/qtb_pkg.sv
package qtb_pkg;

    parameter int unsigned CTRL_W = 4;

    // bit0 enable, bit1 periodic, bit2 divide-by-16, bit3 divide-by-256
    typedef struct packed {
        logic div256;
        logic div16;
        logic periodic;
        logic enable;
    } qtb_ctrl_t;

    typedef enum logic [1:0] {
        REG_LOAD  = 2'd0,
        REG_VALUE = 2'd1,
        REG_CTRL  = 2'd2,
        REG_CLEAR = 2'd3
    } qtb_reg_e;

endpackage

// File: rtl/qtb_prescale.sv
module qtb_prescale #(
    parameter int unsigned PRE_W = 8,
    parameter int unsigned LO_W  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    output logic stb_div1,
    output logic stb_lo,
    output logic stb_hi
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick_en) begin
            s_d.cnt = s_q.cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stb_div1 = tick_en;
    assign stb_lo   = tick_en && (&s_q.cnt[LO_W-1:0]);
    assign stb_hi   = tick_en && (&s_q.cnt);

endmodule

// File: rtl/qtb_decode.sv
module qtb_decode
    import qtb_pkg::*;
#(
    parameter int unsigned N_TIMERS = 4,
    parameter int unsigned ADDR_W   = 8,
    localparam int unsigned IDX_W   = $clog2(N_TIMERS)
) (
    input  logic                addr_unused_guard,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic                rd_en,
    output logic                hit,
    output logic [IDX_W-1:0]    sel_idx,
    output qtb_reg_e            sel_reg,
    output logic [N_TIMERS-1:0] wr_load,
    output logic [N_TIMERS-1:0] wr_value,
    output logic [N_TIMERS-1:0] wr_ctrl,
    output logic [N_TIMERS-1:0] clr_acc
);

    localparam int unsigned IDX_LSB = 5;
    localparam int unsigned IDX_MSB = IDX_LSB + IDX_W - 1;

    logic unused_addr_lo;
    assign unused_addr_lo = ^{addr[1:0], addr_unused_guard};

    assign hit     = (addr[ADDR_W-1:IDX_MSB+1] == '0) && !addr[4];
    assign sel_idx = addr[IDX_MSB:IDX_LSB];
    assign sel_reg = qtb_reg_e'(addr[3:2]);

    for (genvar g = 0; g < N_TIMERS; g++) begin : g_strobe
        logic mine;
        assign mine        = hit && (sel_idx == IDX_W'(g));
        assign wr_load[g]  = wr_en && mine && (sel_reg == REG_LOAD);
        assign wr_value[g] = wr_en && mine && (sel_reg == REG_VALUE);
        assign wr_ctrl[g]  = wr_en && mine && (sel_reg == REG_CTRL);
        assign clr_acc[g]  = (wr_en || rd_en) && mine && (sel_reg == REG_CLEAR);
    end

endmodule

// File: rtl/qtb_timer.sv
module qtb_timer
    import qtb_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_div1,
    input  logic             stb_div16,
    input  logic             stb_div256,
    input  logic             wr_load,
    input  logic             wr_value,
    input  logic             wr_ctrl,
    input  logic             clr_acc,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] load_o,
    output logic [CNT_W-1:0] value_o,
    output qtb_ctrl_t        ctrl_o,
    output logic             irq_o
);

    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam qtb_ctrl_t        CTRL_RST = '{div256: 1'b0, div16: 1'b0,
                                              periodic: 1'b1, enable: 1'b0};

    typedef struct packed {
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] value;
        qtb_ctrl_t        ctrl;
        logic             irq;
        logic             expired;
    } tmr_st_t;

    tmr_st_t   s_d, s_q;
    logic      step;
    logic      running;
    qtb_ctrl_t ctrl_new;

    assign ctrl_new = qtb_ctrl_t'(wdata[CTRL_W-1:0]);

    always_comb begin
        if (s_q.ctrl.div256) begin
            step = stb_div256;
        end else if (s_q.ctrl.div16) begin
            step = stb_div16;
        end else begin
            step = stb_div1;
        end
        running = s_q.ctrl.enable && !s_q.irq && !s_q.expired;

        s_d = s_q;
        if (wr_load) begin
            s_d.load    = wdata;
            s_d.value   = wdata;
            s_d.irq     = 1'b0;
            s_d.expired = 1'b0;
        end else if (wr_value) begin
            s_d.value   = wdata;
            s_d.expired = 1'b0;
        end else if (wr_ctrl) begin
            s_d.ctrl = ctrl_new;
            s_d.irq  = 1'b0;
            if (ctrl_new.enable) begin
                s_d.value   = s_q.load;
                s_d.expired = 1'b0;
            end
        end else if (clr_acc) begin
            s_d.irq = 1'b0;
            if (s_q.ctrl.periodic) begin
                s_d.value   = s_q.load;
                s_d.expired = 1'b0;
            end
        end else if (running && step) begin
            if (s_q.value[CNT_W-1:1] == '0) begin
                s_d.value   = '0;
                s_d.irq     = 1'b1;
                s_d.expired = 1'b1;
            end else begin
                s_d.value = s_q.value - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.load    <= CNT_MAX;
            s_q.value   <= CNT_MAX;
            s_q.ctrl    <= CTRL_RST;
            s_q.irq     <= 1'b0;
            s_q.expired <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign load_o  = s_q.load;
    assign value_o = s_q.value;
    assign ctrl_o  = s_q.ctrl;
    assign irq_o   = s_q.irq;

endmodule

// File: rtl/qtimer_bank.sv
module qtimer_bank
    import qtb_pkg::*;
#(
    parameter int unsigned N_TIMERS = 4,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned CNT_W    = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                wr_en,
    input  logic                rd_en,
    output logic [DATA_W-1:0]   rdata,
    output logic [N_TIMERS-1:0] irq
);

    localparam int unsigned IDX_W = $clog2(N_TIMERS);
    localparam int unsigned PRE_W = 8;
    localparam int unsigned LO_W  = 4;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:CNT_W];

    logic stb_div1, stb_lo, stb_hi;

    qtb_prescale #(.PRE_W(PRE_W), .LO_W(LO_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .stb_div1 (stb_div1),
        .stb_lo   (stb_lo),
        .stb_hi   (stb_hi)
    );

    logic                hit;
    logic [IDX_W-1:0]    sel_idx;
    qtb_reg_e            sel_reg;
    logic [N_TIMERS-1:0] wr_load, wr_value, wr_ctrl, clr_acc;

    qtb_decode #(.N_TIMERS(N_TIMERS), .ADDR_W(ADDR_W)) u_dec (
        .addr_unused_guard (1'b0),
        .addr     (addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .hit      (hit),
        .sel_idx  (sel_idx),
        .sel_reg  (sel_reg),
        .wr_load  (wr_load),
        .wr_value (wr_value),
        .wr_ctrl  (wr_ctrl),
        .clr_acc  (clr_acc)
    );

    logic [CNT_W-1:0] load_arr  [N_TIMERS];
    logic [CNT_W-1:0] value_arr [N_TIMERS];
    qtb_ctrl_t        ctrl_arr  [N_TIMERS];

    for (genvar g = 0; g < N_TIMERS; g++) begin : g_tmr
        qtb_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk        (clk),
            .rst_n      (rst_n),
            .stb_div1   (stb_div1),
            .stb_div16  (stb_lo),
            .stb_div256 (stb_hi),
            .wr_load    (wr_load[g]),
            .wr_value   (wr_value[g]),
            .wr_ctrl    (wr_ctrl[g]),
            .clr_acc    (clr_acc[g]),
            .wdata      (wdata[CNT_W-1:0]),
            .load_o     (load_arr[g]),
            .value_o    (value_arr[g]),
            .ctrl_o     (ctrl_arr[g]),
            .irq_o      (irq[g])
        );
    end

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_st_t;

    rd_st_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (rd_en) begin
            r_d.rdata = '0;
            if (hit) begin
                case (sel_reg)
                    REG_LOAD:  r_d.rdata = DATA_W'(load_arr[sel_idx]);
                    REG_VALUE: r_d.rdata = DATA_W'(value_arr[sel_idx]);
                    REG_CTRL:  r_d.rdata = DATA_W'(ctrl_arr[sel_idx]);
                    default:   r_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata = r_q.rdata;

endmodule

// File: rtl/qtb_checker.sv
module qtb_checker #(
    parameter int unsigned N_TIMERS = 4,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned CNT_W    = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   addr,
    input logic                wr_en,
    input logic                rd_en,
    input logic [DATA_W-1:0]   rdata,
    input logic [N_TIMERS-1:0] irq
);

    logic unused_addr_lo;
    assign unused_addr_lo = ^addr[1:0];

    logic in_win;
    assign in_win = (addr[ADDR_W-1:7] == '0) && !addr[4];

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R10

    AST_RDATA_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:CNT_W] == '0); // R10

    AST_OUT_OF_WINDOW_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !in_win) |=> (rdata == '0)); // R1

    for (genvar g = 0; g < N_TIMERS; g++) begin : g_chk
        logic touch, ld_wr, ct_wr, ack;
        assign touch = (wr_en || rd_en) && (addr[6:5] == 2'(g));
        assign ld_wr = wr_en && in_win && (addr[6:5] == 2'(g)) && (addr[3:2] == 2'd0);
        assign ct_wr = wr_en && in_win && (addr[6:5] == 2'(g)) && (addr[3:2] == 2'd2);
        assign ack   = (wr_en || rd_en) && in_win && (addr[6:5] == 2'(g)) && (addr[3:2] == 2'd3);

        AST_LOAD_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
            ld_wr |=> !irq[g]); // R3

        AST_CTRL_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
            ct_wr |=> !irq[g]); // R4

        AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
            ack |=> !irq[g]); // R5

        AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[g] && !touch) |=> irq[g]); // R7
    end

endmodule

bind qtimer_bank qtb_checker #(
    .N_TIMERS (N_TIMERS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W)
) u_qtb_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .rdata (rdata),
    .irq   (irq)
);

// File: tb/qtimer_bank_test.sv
module qtimer_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int MASK = 24'hFFFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic [3:0]  irq;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    int tick_mode = 0;
    logic [7:0] lf = 8'h5A;

    qtimer_bank uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
        .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // tick pattern: always-on or pseudo-random
    always @(negedge clk) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        tick_en = (tick_mode == 0) ? 1'b1 : lf[0];
    end

    // behavioural reference model
    int  m_ld [4];
    int  m_val[4];
    int  m_ctl[4];
    bit  m_irq[4];
    bit  m_exp[4];
    int  m_pre, m_rd, p_old, t, off;
    bit  hit, acc, step;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_ld[i] = MASK; m_val[i] = MASK; m_ctl[i] = 2;
                m_irq[i] = 0; m_exp[i] = 0;
            end
            m_pre = 0; m_rd = 0;
        end else begin
            p_old = m_pre;
            if (tick_en) m_pre = (m_pre + 1) % 256;
            hit = (addr[7] == 1'b0) && (addr[4] == 1'b0);
            t   = int'(addr[6:5]);
            off = int'(addr[3:2]);
            if (rd_en) begin
                if (!hit)          m_rd = 0;
                else if (off == 0) m_rd = m_ld[t];
                else if (off == 1) m_rd = m_val[t];
                else if (off == 2) m_rd = m_ctl[t];
                else               m_rd = 0;
            end
            for (int i = 0; i < 4; i++) begin
                if ((m_ctl[i] & 8) != 0)      step = tick_en && (p_old == 255);
                else if ((m_ctl[i] & 4) != 0) step = tick_en && ((p_old % 16) == 15);
                else                          step = tick_en;
                acc = hit && (t == i);
                if (acc && wr_en && off == 0) begin
                    m_ld[i] = wdata & MASK; m_val[i] = m_ld[i]; m_irq[i] = 0; m_exp[i] = 0;
                end else if (acc && wr_en && off == 1) begin
                    m_val[i] = wdata & MASK; m_exp[i] = 0;
                end else if (acc && wr_en && off == 2) begin
                    m_ctl[i] = wdata & 15; m_irq[i] = 0;
                    if ((m_ctl[i] & 1) != 0) begin m_val[i] = m_ld[i]; m_exp[i] = 0; end
                end else if (acc && (wr_en || rd_en) && off == 3) begin
                    m_irq[i] = 0;
                    if ((m_ctl[i] & 2) != 0) begin m_val[i] = m_ld[i]; m_exp[i] = 0; end
                end else if ((m_ctl[i] & 1) != 0 && !m_irq[i] && !m_exp[i] && step) begin
                    if (m_val[i] <= 1) begin m_val[i] = 0; m_irq[i] = 1; m_exp[i] = 1; end
                    else m_val[i] = m_val[i] - 1;
                end
            end
        end
    end

    // every-cycle comparison against the model (R7, R10, R12)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [3:0] exp_irq;
            exp_irq = {m_irq[3], m_irq[2], m_irq[1], m_irq[0]};
            checks++;
            if (irq !== exp_irq || rdata !== 32'(m_rd)) begin
                fails++;
                $display("FAIL R7/R10/R12 model compare t=%0t: irq=%h exp=%h rdata=%h exp=%h",
                         $time, irq, exp_irq, rdata, m_rd);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic wait_irq(input int i, input int maxc);
        for (int k = 0; k < maxc && !irq[i]; k++) @(negedge clk);
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            finished = 1;
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        chk("R2 irq after reset", 32'(irq), 32'h0);
        chk("R2 rdata after reset", rdata, 32'h0);
        rd(8'h08, v); chk("R2 control reset", v, 32'h2);
        rd(8'h40, v); chk("R2 reload reset", v, 32'hFFFFFF);
        rd(8'h64, v); chk("R2 count reset", v, 32'hFFFFFF);

        wr(8'h10, 32'h123);
        wr(8'h80, 32'h55);
        rd(8'h00, v); chk("R1 out-of-window writes ignored", v, 32'hFFFFFF);
        rd(8'h90, v); chk("R1 out-of-window read", v, 32'h0);

        rd(8'h24, v); repeat (10) @(negedge clk);
        rd(8'h24, v2); chk("R11 disabled timer holds", v2, v);

        wr(8'h60, 32'hABCDEF12);
        rd(8'h60, v); chk("R3 reload masked", v, 32'hCDEF12);
        rd(8'h64, v); chk("R3 count copied", v, 32'hCDEF12);
        wr(8'h68, 32'hFFFFFFF2);
        rd(8'h68, v); chk("R4 control upper bits dropped", v, 32'h2);
        wr(8'h64, 32'h7F000010);
        rd(8'h64, v); chk("R10 count write masked", v, 32'h10);

        // periodic, divide-by-1
        wr(8'h00, 32'd5); wr(8'h08, 32'h3);
        wait_irq(0, 50); chk("R7 periodic expiry", 32'(irq[0]), 32'h1);
        rd(8'h04, v); chk("R7 count at zero", v, 32'h0);
        repeat (5) @(negedge clk); chk("R7 irq sticky", 32'(irq[0]), 32'h1);
        rd(8'h0C, v); chk("R5 ack read value", v, 32'h0);
        chk("R5 ack drops irq", 32'(irq[0]), 32'h0);
        wait_irq(0, 50); chk("R8 periodic restarts", 32'(irq[0]), 32'h1);
        wr(8'h08, 32'h2); chk("R4 disable discards irq", 32'(irq[0]), 32'h0);
        repeat (20) @(negedge clk); chk("R11 disabled stays quiet", 32'(irq[0]), 32'h0);

        // one-shot
        wr(8'h20, 32'd3); wr(8'h28, 32'h1);
        wait_irq(1, 50); chk("R7 one-shot expiry", 32'(irq[1]), 32'h1);
        wr(8'h2C, 32'h0); chk("R5 ack write drops irq", 32'(irq[1]), 32'h0);
        repeat (30) @(negedge clk); chk("R9 one-shot stays stopped", 32'(irq[1]), 32'h0);
        rd(8'h24, v); chk("R9 one-shot count zero", v, 32'h0);
        wr(8'h24, 32'd4);
        wait_irq(1, 50); chk("R9 count write restarts", 32'(irq[1]), 32'h1);
        wr(8'h28, 32'h0);

        // prescaled timers with sparse ticks
        tick_mode = 1;
        wr(8'h40, 32'd2); wr(8'h48, 32'h7);
        wait_irq(2, 400); chk("R6 divide-by-16 expiry", 32'(irq[2]), 32'h1);
        rd(8'h4C, v); chk("R5 periodic ack reloads", 32'(irq[2]), 32'h0);
        wr(8'h48, 32'h2);
        wr(8'h60, 32'd1); wr(8'h68, 32'hF);
        wait_irq(3, 3000); chk("R6 both divide bits -> 256", 32'(irq[3]), 32'h1);
        wr(8'h60, 32'd9); chk("R3 reload drops irq", 32'(irq[3]), 32'h0);
        repeat (40) @(negedge clk);

        finished = 1;
        summary();
        $finish;
    end

endmodule